// File: doc/BRIEF.md
# DLL Start-Up and Command Readiness Sequencer

This block sits on the controller side of a memory that relies on an internal delay-locked loop. It decides when the command logic may start issuing requests. It drives an active-low DLL-off pin and keeps it low until supply power is good and the memory clock is reported stable. It then releases the pin and counts memory-clock cycles until the loop can be assumed locked. While it does this, it also counts memory-clock cycles that carry no read, because the output-impedance calibration can only settle in cycles that do not drive the outputs. The ready flag rises only when both counts are complete.

The sequencer runs on a free-running reference clock. Each memory-clock cycle reaches it as a one-cycle `mclk_tick` pulse that has already been brought into the reference domain. If no tick arrives for a programmed number of reference cycles, the memory clock is taken to have stopped long enough to reset the loop. The whole lock procedure then runs again once ticks resume. A request to change frequency also restarts the procedure. A request for a frequency below the loop's lower limit is refused and flagged instead.

Top module: `dll_ready_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after reset, `dll_off_n`, `cmd_ready` and `freq_err` are all 0. Reset also clears a pending `freq_err`.
- R2: `dll_off_n` stays 0 until `pwr_good` is high and `clk_stable` has then been sampled high. It rises in the reference cycle after `clk_stable` is sampled high in the clock-wait phase.
- R3: After `dll_off_n` rises, `cmd_ready` stays 0 through LOCK_CYCLES `mclk_tick` pulses. It rises one reference cycle after the pulse that completes the count.
- R4: `cmd_ready` also needs NONREAD_CYCLES pulses of `mclk_tick` during which `rd_issue` is 0. Pulses with `rd_issue` = 1 do not count. The two counts run at the same time.
- R5: While locking or ready, STOP_TICKS consecutive reference cycles without `mclk_tick` drop `cmd_ready` one cycle later, and `dll_off_n` stays 1. A gap of STOP_TICKS-1 cycles has no effect. The first tick after the stop starts a full fresh LOCK_CYCLES and NONREAD_CYCLES wait.
- R6: A `freq_req` pulse with `freq_mhz` >= MIN_MHZ (120 included) is accepted. The cycle after it, `dll_off_n` and `cmd_ready` are 0 and `freq_err` is 0. The full lock wait then repeats.
- R7: A `freq_req` pulse with `freq_mhz` < MIN_MHZ sets `freq_err` from the next cycle. `dll_off_n` and `cmd_ready` are left unchanged. `freq_err` holds until an accepted request or a reset.
- R8: `clk_stable` sampled 0 after release drives `dll_off_n` and `cmd_ready` to 0 in the next cycle. Once the clock is stable again, the full lock wait repeats.
- R9: `pwr_good` sampled 0 returns the sequencer to the power wait: `dll_off_n` and `cmd_ready` are 0 in the next cycle. After power returns, `dll_off_n` stays 0 for at least one cycle even when `clk_stable` is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supplies are up and stable |
| clk_stable | input | 1 | Memory clock is running and stable |
| mclk_tick | input | 1 | One pulse per memory-clock cycle, in the reference domain |
| rd_issue | input | 1 | The current memory cycle carries a read |
| freq_req | input | 1 | One-cycle request to change the operating frequency |
| freq_mhz | input | FREQ_W | Requested frequency in MHz, valid with `freq_req` |
| dll_off_n | output | 1 | Active-low DLL-off drive to the memory |
| cmd_ready | output | 1 | Commands may be issued |
| freq_err | output | 1 | Last frequency request was below the DLL's limit |

## Verification
Most faults in the phase register or the counters show up as a wrong edge time on `cmd_ready` or `dll_off_n`. So the checks place samples on both sides of every count boundary: one cycle before and one cycle after the expected rise, and on the cycle when a stop, frequency change or clock loss should take effect. A counter that clears at the wrong time, or counts read cycles as non-read, moves the rise of `cmd_ready` by at least one tick. That is caught on the first relock after the fault. A stop detector that is off by one either drops `cmd_ready` after the short gap of STOP_TICKS-1 cycles or keeps it after a full gap. Both show at the port within a cycle.

// File: rtl/dll_ready_pkg.sv
package dll_ready_pkg;
  typedef enum logic [2:0] {
    ST_PWR_WAIT = 3'd0,
    ST_CLK_WAIT = 3'd1,
    ST_LOCK     = 3'd2,
    ST_IMP      = 3'd3,
    ST_READY    = 3'd4,
    ST_STOPPED  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/dll_ready_cnt.sv
// Saturating up-counter; full stays high once LIMIT is reached.
module dll_ready_cnt #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic full
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != LIM_V) cnt <= cnt + 1'b1;
  end

  assign full = (cnt == LIM_V);
endmodule

// File: rtl/dll_ready_fguard.sv
// Splits a frequency request into accepted or refused against the DLL floor.
module dll_ready_fguard #(
  parameter int FREQ_W  = 10,
  parameter int MIN_MHZ = 120
) (
  input  logic              req,
  input  logic [FREQ_W-1:0] mhz,
  output logic              accept,
  output logic              reject
);
  localparam logic [FREQ_W-1:0] FLOOR = FREQ_W'(MIN_MHZ);

  assign accept = req && (mhz >= FLOOR);
  assign reject = req && (mhz <  FLOOR);
endmodule

// File: rtl/dll_ready_seq.sv
module dll_ready_seq
  import dll_ready_pkg::*;
#(
  parameter int LOCK_CYCLES    = 1024,
  parameter int NONREAD_CYCLES = 1024,
  parameter int STOP_TICKS     = 3,
  parameter int FREQ_W         = 10,
  parameter int MIN_MHZ        = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              clk_stable,
  input  logic              mclk_tick,
  input  logic              rd_issue,
  input  logic              freq_req,
  input  logic [FREQ_W-1:0] freq_mhz,
  output logic              dll_off_n,
  output logic              cmd_ready,
  output logic              freq_err
);
  seq_state_e state, nxt;
  logic counting, watching;
  logic lock_full, nr_full, idle_full;
  logic f_accept, f_reject;

  assign counting = (state == ST_LOCK) || (state == ST_IMP);
  assign watching = counting || (state == ST_READY);

  dll_ready_cnt #(.LIMIT(LOCK_CYCLES)) u_lock_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!counting),
    .inc(mclk_tick), .full(lock_full)
  );

  dll_ready_cnt #(.LIMIT(NONREAD_CYCLES)) u_nr_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!counting),
    .inc(mclk_tick && !rd_issue), .full(nr_full)
  );

  dll_ready_cnt #(.LIMIT(STOP_TICKS)) u_idle_cnt (
    .clk(clk), .rst_n(rst_n), .clr(mclk_tick || !watching),
    .inc(1'b1), .full(idle_full)
  );

  dll_ready_fguard #(.FREQ_W(FREQ_W), .MIN_MHZ(MIN_MHZ)) u_fguard (
    .req(freq_req), .mhz(freq_mhz), .accept(f_accept), .reject(f_reject)
  );

  always_comb begin
    nxt = state;
    if (!pwr_good) begin
      nxt = ST_PWR_WAIT;
    end else begin
      case (state)
        ST_PWR_WAIT: nxt = ST_CLK_WAIT;
        ST_CLK_WAIT: if (clk_stable) nxt = ST_LOCK;
        default: begin
          if (!clk_stable || f_accept) begin
            nxt = ST_CLK_WAIT;
          end else if (state == ST_STOPPED) begin
            if (mclk_tick) nxt = ST_LOCK;
          end else if (idle_full) begin
            nxt = ST_STOPPED;
          end else if (state == ST_LOCK) begin
            if (lock_full) nxt = nr_full ? ST_READY : ST_IMP;
          end else if (state == ST_IMP) begin
            if (nr_full) nxt = ST_READY;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_PWR_WAIT;
    else        state <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        freq_err <= 1'b0;
    else if (f_accept) freq_err <= 1'b0;
    else if (f_reject) freq_err <= 1'b1;
  end

  assign dll_off_n = (state != ST_PWR_WAIT) && (state != ST_CLK_WAIT);
  assign cmd_ready = (state == ST_READY);
endmodule

// File: rtl/dll_ready_chk.sv
module dll_ready_chk #(
  parameter int FREQ_W  = 10,
  parameter int MIN_MHZ = 120
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              clk_stable,
  input logic              freq_req,
  input logic [FREQ_W-1:0] freq_mhz,
  input logic              dll_off_n,
  input logic              cmd_ready,
  input logic              freq_err,
  input logic              lock_full,
  input logic              nr_full,
  input logic              idle_full
);
  localparam logic [FREQ_W-1:0] FLOOR = FREQ_W'(MIN_MHZ);

  p_power_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!dll_off_n && !cmd_ready));

  p_unstable_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_stable |=> !dll_off_n);

  p_ready_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> ($past(lock_full) && $past(nr_full)));

  p_stop_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && idle_full) |=> !cmd_ready);

  p_low_freq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_req && freq_mhz < FLOOR) |=> freq_err);

  p_freq_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_req && freq_mhz >= FLOOR) |=> (!freq_err && !cmd_ready));
endmodule

bind dll_ready_seq dll_ready_chk #(.FREQ_W(FREQ_W), .MIN_MHZ(MIN_MHZ)) u_chk (.*);

// File: tb/dll_ready_seq_bench.sv
module dll_ready_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LOCKN      = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_good = 1'b0;
  logic       clk_stable = 1'b0;
  logic       mclk_tick = 1'b1;
  logic       rd_issue = 1'b0;
  logic       freq_req = 1'b0;
  logic [9:0] freq_mhz = 10'd0;
  logic       dll_off_n, cmd_ready, freq_err;

  typedef struct {
    logic  d;
    logic  r;
    logic  e;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  dll_ready_seq u_dll_ready_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .clk_stable(clk_stable),
    .mclk_tick(mclk_tick), .rd_issue(rd_issue), .freq_req(freq_req),
    .freq_mhz(freq_mhz), .dll_off_n(dll_off_n), .cmd_ready(cmd_ready),
    .freq_err(freq_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_out(string tag, logic d, logic r, logic e);
    exp_t x;
    x.d = d; x.r = r; x.e = e; x.tag = tag;
    exp_q.push_back(x);
  endtask

  // Monitor: compares queued expectations against outputs at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t x;
        x = exp_q.pop_front();
        n_cmp++;
        if (dll_off_n !== x.d || cmd_ready !== x.r || freq_err !== x.e) begin
          n_bad++;
          $display("FAIL %s: got dll_off_n=%b cmd_ready=%b freq_err=%b, expected %b %b %b",
                   x.tag, dll_off_n, cmd_ready, freq_err, x.d, x.r, x.e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_out("R1 held in reset", 0, 0, 0);
    rst_n = 1'b1; pwr_good = 1'b1;
    step(1);
    expect_out("R2 power good, clock not stable", 0, 0, 0);
    step(3);
    expect_out("R2 still waiting for clock", 0, 0, 0);
    clk_stable = 1'b1;
    step(1);
    expect_out("R2 release after stable clock", 1, 0, 0);
    step(LOCKN);
    expect_out("R3 ready low at final lock tick", 1, 0, 0);
    step(1);
    expect_out("R3 ready after lock count", 1, 1, 0);

    // R6 accepted change, then R4 read cycles delay readiness
    freq_req = 1'b1; freq_mhz = 10'd200;
    step(1);
    expect_out("R6 accepted change resets DLL", 0, 0, 0);
    freq_req = 1'b0; rd_issue = 1'b1;
    step(1);
    expect_out("R6 relock begins", 1, 0, 0);
    step(100);
    rd_issue = 1'b0;
    step(LOCKN);
    expect_out("R4 reads do not count as non-read", 1, 0, 0);
    step(1);
    expect_out("R4 ready after non-read count", 1, 1, 0);

    // R7 refused low frequency
    freq_req = 1'b1; freq_mhz = 10'd119;
    step(1);
    expect_out("R7 low frequency flagged, no restart", 1, 1, 1);
    freq_req = 1'b0;
    step(2);
    expect_out("R7 flag holds", 1, 1, 1);
    freq_req = 1'b1; freq_mhz = 10'd120;
    step(1);
    expect_out("R6 boundary 120 accepted clears flag", 0, 0, 0);
    freq_req = 1'b0;
    step(1);
    expect_out("R6 relock after boundary change", 1, 0, 0);
    step(LOCKN);
    expect_out("R6 full wait repeated", 1, 0, 0);
    step(1);
    expect_out("R6 ready again", 1, 1, 0);

    // R5 clock stop detection
    mclk_tick = 1'b0;
    step(2);
    mclk_tick = 1'b1;
    step(1);
    expect_out("R5 short gap ignored", 1, 1, 0);
    step(2);
    expect_out("R5 short gap still ignored", 1, 1, 0);
    mclk_tick = 1'b0;
    step(3);
    expect_out("R5 full gap not yet acted on", 1, 1, 0);
    step(1);
    expect_out("R5 stop drops ready, DLL pin high", 1, 0, 0);
    step(4);
    expect_out("R5 stays stopped", 1, 0, 0);
    mclk_tick = 1'b1;
    step(1);
    expect_out("R5 resume enters lock", 1, 0, 0);
    step(LOCKN);
    expect_out("R5 full relock required", 1, 0, 0);
    step(1);
    expect_out("R5 ready after relock", 1, 1, 0);

    // R8 clock becomes unstable
    clk_stable = 1'b0;
    step(1);
    expect_out("R8 unstable clock forces DLL off", 0, 0, 0);
    step(2);
    expect_out("R8 holds off while unstable", 0, 0, 0);
    clk_stable = 1'b1;
    step(1);
    expect_out("R8 release after stable again", 1, 0, 0);

    // R9 power loss
    pwr_good = 1'b0;
    step(1);
    expect_out("R9 power loss forces DLL off", 0, 0, 0);
    pwr_good = 1'b1;
    step(1);
    expect_out("R9 one cycle low after power return", 0, 0, 0);
    step(1);
    expect_out("R9 release after power return", 1, 0, 0);

    // R1 reset clears error flag
    freq_req = 1'b1; freq_mhz = 10'd50;
    step(1);
    expect_out("R7 flag set before reset", 1, 0, 1);
    freq_req = 1'b0; rst_n = 1'b0;
    step(1);
    expect_out("R1 reset clears flag", 0, 0, 0);
    rst_n = 1'b1;

    step(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule